// File: doc/BRIEF.md
# Vector half-precision class test unit

This unit classifies one half-precision value per lane of a SIMD vector and checks each classification against a per-lane selection mask. The mask has ten bits, one for each floating-point category. A lane's result bit is 1 when its value's category is selected in that lane's mask and the lane is enabled in the execute mask presented with the request. Lanes that are not enabled produce 0. Denormal inputs are classified as denormals and are never flushed to zero first.

A request is a one-cycle strobe carrying an opcode. Opcode 20 writes the lane results into the destination mask register and leaves the execute-mask register unchanged. Opcode 21 writes the same results into both registers, so it also narrows the set of lanes that later operations act on. Any other opcode leaves both registers as they were and raises an error flag for one cycle. Both registers load on the clock edge that samples the strobe, and their new contents are visible in the following cycle.

Top module: `fpcls_unit`

## Requirements
- R1: The negative categories use these mask bit positions: signalling NaN at bit 0, quiet NaN at bit 1, negative infinity at bit 2, negative normal at bit 3, negative denormal at bit 4, negative zero at bit 5.
- R2: The positive categories use these mask bit positions: positive zero at bit 6, positive denormal at bit 7, positive normal at bit 8, positive infinity at bit 9. The value is IEEE half precision: sign at bit 15, exponent at bits 14:10, mantissa at bits 9:0.
- R3: A value with exponent 0x1F and a nonzero mantissa is a quiet NaN when mantissa bit 9 is 1, and a signalling NaN when that bit is 0. The sign does not change a NaN's category.
- R4: A value with exponent 0 and a nonzero mantissa is classified as a denormal of its sign and not as a zero.
- R5: For each enabled lane i, bit i of the result is 1 exactly when the mask bit for the value's category is 1. Other mask bits have no effect.
- R6: A lane whose execute-mask input bit is 0 when the request is sampled writes 0 to its destination bit.
- R7: Opcode 20 loads the destination register with the result and leaves the execute-mask register unchanged.
- R8: Opcode 21 loads both the destination register and the execute-mask register with the same result.
- R9: Both registers update only on the edge that samples a valid strobe and hold their values in every other cycle.
- R10: A valid strobe with any opcode other than 20 or 21 leaves both registers unchanged and sets the error flag for exactly the following cycle.
- R11: After reset the destination register is all zeros, the execute-mask register is all ones, and the error flag is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_vld | input | 1 | Request strobe, one cycle per request |
| req_opc | input | 8 | Opcode: 20 for the class test, 21 for the test that also writes the execute mask |
| lane_val | input | LANES*16 | Half-precision value per lane; lane i is at bits 16*i+15 : 16*i |
| lane_sel | input | LANES*10 | Category selection mask per lane; lane i is at bits 10*i+9 : 10*i |
| exec_in | input | LANES | Execute mask sampled with the request; bit i enables lane i |
| dst_mask | output | LANES | Destination mask register |
| exec_mask | output | LANES | Execute-mask register |
| opc_err | output | 1 | High for one cycle after a request with an unsupported opcode |

## Verification
The ten category cases are applied across all lanes twice. First each lane selects only its own category, which must give all ones. Then each lane selects every category except its own, which must give all zeros. Together these show that each mask position maps to one category. Boundary encodings are applied next: NaNs with and without mantissa bit 9, NaNs of both signs, the smallest and largest denormals, and the largest normal. These separate the quiet and signalling NaN cases, and denormals from zeros and normals. Alternating execute masks, with masks that select several categories at once, show that disabled lanes are forced to 0 and that selected categories are combined by OR. A sequence of opcodes 20 and 21, unsupported opcodes and idle cycles shows which register each request writes and that neither register changes between requests.

// File: rtl/fpcls_pkg.sv
package fpcls_pkg;
  localparam int VAL_W = 16;
  localparam int SEL_W = 10;
  localparam int EXP_W = 5;
  localparam int MAN_W = 10;
  localparam int OPC_W = 8;

  localparam logic [OPC_W-1:0] OPC_TEST   = 8'd20;
  localparam logic [OPC_W-1:0] OPC_TEST_X = 8'd21;

  // category bit positions inside a selection mask
  localparam int CAT_SNAN  = 0;
  localparam int CAT_QNAN  = 1;
  localparam int CAT_NINF  = 2;
  localparam int CAT_NNORM = 3;
  localparam int CAT_NDEN  = 4;
  localparam int CAT_NZERO = 5;
  localparam int CAT_PZERO = 6;
  localparam int CAT_PDEN  = 7;
  localparam int CAT_PNORM = 8;
  localparam int CAT_PINF  = 9;
endpackage

// File: rtl/fpcls_half_cat.sv
module fpcls_half_cat
  import fpcls_pkg::*;
(
  input  logic [VAL_W-1:0] val,
  output logic [SEL_W-1:0] cat
);
  logic             sgn;
  logic [EXP_W-1:0] ex;
  logic [MAN_W-1:0] man;

  assign sgn = val[VAL_W-1];
  assign ex  = val[VAL_W-2 -: EXP_W];
  assign man = val[MAN_W-1:0];

  always_comb begin
    cat = '0;
    if (ex == '1) begin
      if (man != '0) begin
        if (man[MAN_W-1]) cat[CAT_QNAN] = 1'b1;
        else              cat[CAT_SNAN] = 1'b1;
      end else begin
        if (sgn) cat[CAT_NINF] = 1'b1;
        else     cat[CAT_PINF] = 1'b1;
      end
    end else if (ex == '0) begin
      // denormals kept as denormals, no flush
      if (man == '0) begin
        if (sgn) cat[CAT_NZERO] = 1'b1;
        else     cat[CAT_PZERO] = 1'b1;
      end else begin
        if (sgn) cat[CAT_NDEN] = 1'b1;
        else     cat[CAT_PDEN] = 1'b1;
      end
    end else begin
      if (sgn) cat[CAT_NNORM] = 1'b1;
      else     cat[CAT_PNORM] = 1'b1;
    end
  end
endmodule

// File: rtl/fpcls_lane_array.sv
module fpcls_lane_array
  import fpcls_pkg::*;
#(
  parameter int LANES = 64
) (
  input  logic [LANES*VAL_W-1:0] lane_val,
  input  logic [LANES*SEL_W-1:0] lane_sel,
  input  logic [LANES-1:0]       lane_en,
  output logic [LANES-1:0]       hit
);
  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic [SEL_W-1:0] cat;

    fpcls_half_cat u_cat (
      .val (lane_val[i*VAL_W +: VAL_W]),
      .cat (cat)
    );

    assign hit[i] = lane_en[i] & (|(cat & lane_sel[i*SEL_W +: SEL_W]));
  end
endmodule

// File: rtl/fpcls_unit.sv
module fpcls_unit
  import fpcls_pkg::*;
#(
  parameter int LANES = 64
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req_vld,
  input  logic [OPC_W-1:0]       req_opc,
  input  logic [LANES*VAL_W-1:0] lane_val,
  input  logic [LANES*SEL_W-1:0] lane_sel,
  input  logic [LANES-1:0]       exec_in,
  output logic [LANES-1:0]       dst_mask,
  output logic [LANES-1:0]       exec_mask,
  output logic                   opc_err
);
  logic [LANES-1:0] hit;
  logic [LANES-1:0] dst_q, dst_d;
  logic [LANES-1:0] exe_q, exe_d;
  logic             err_q, err_d;
  logic             dst_en, exe_en;
  logic             opc_ok;

  fpcls_lane_array #(.LANES(LANES)) u_lanes (
    .lane_val (lane_val),
    .lane_sel (lane_sel),
    .lane_en  (exec_in),
    .hit      (hit)
  );

  assign opc_ok = (req_opc == OPC_TEST) || (req_opc == OPC_TEST_X);

  always_comb begin
    dst_en = req_vld && opc_ok;
    exe_en = req_vld && (req_opc == OPC_TEST_X);
    dst_d  = dst_en ? hit : dst_q;
    exe_d  = exe_en ? hit : exe_q;
    err_d  = req_vld && !opc_ok;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dst_q <= '0;
      exe_q <= '1;
      err_q <= 1'b0;
    end else begin
      dst_q <= dst_d;
      exe_q <= exe_d;
      err_q <= err_d;
    end
  end

  assign dst_mask  = dst_q;
  assign exec_mask = exe_q;
  assign opc_err   = err_q;

  // R6: disabled lanes never carry a 1 after a successful request
  a_r6_disabled_lane_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (req_vld && opc_ok) |=> ((dst_mask & ~$past(exec_in)) == '0));

  // R7: plain test keeps the execute-mask register
  a_r7_plain_keeps_exec: assert property (@(posedge clk) disable iff (!rst_n)
    (req_vld && req_opc == OPC_TEST) |=> $stable(exec_mask));

  // R8: the X test leaves both registers equal
  a_r8_x_writes_both: assert property (@(posedge clk) disable iff (!rst_n)
    (req_vld && req_opc == OPC_TEST_X) |=> (exec_mask == dst_mask));

  // R9: no strobe, no change
  a_r9_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !req_vld |=> ($stable(dst_mask) && $stable(exec_mask) && !opc_err));

  // R10: unsupported opcode flags and changes nothing
  a_r10_bad_opc: assert property (@(posedge clk) disable iff (!rst_n)
    (req_vld && !opc_ok) |=> (opc_err && $stable(dst_mask) && $stable(exec_mask)));
endmodule

// File: tb/test_fpcls_unit.sv
module test_fpcls_unit;
  localparam int LANES = 64;

  logic                clk = 1'b0;
  logic                rst_n = 1'b0;
  logic                req_vld = 1'b0;
  logic [7:0]          req_opc = '0;
  logic [LANES*16-1:0] lane_val = '0;
  logic [LANES*10-1:0] lane_sel = '0;
  logic [LANES-1:0]    exec_in = '0;
  logic [LANES-1:0]    dst_mask, exec_mask;
  logic                opc_err;

  int checks = 0;
  int fails = 0;
  logic done = 1'b0;

  always #4 clk = ~clk;

  fpcls_unit #(.LANES(LANES)) i_fpcls_unit (
    .clk, .rst_n, .req_vld, .req_opc, .lane_val, .lane_sel,
    .exec_in, .dst_mask, .exec_mask, .opc_err
  );

  // one representative encoding per category index
  function automatic logic [15:0] rep(input int c);
    case (c)
      0: return 16'h7C01; 1: return 16'h7E00; 2: return 16'hFC00;
      3: return 16'hBC00; 4: return 16'h8001; 5: return 16'h8000;
      6: return 16'h0000; 7: return 16'h0001; 8: return 16'h3C00;
      default: return 16'h7C00;
    endcase
  endfunction

  // independent category model from the requirement text
  function automatic int cat_of(input logic [15:0] v);
    if (v[14:10] == 5'h1F && v[9:0] != 0) return v[9] ? 1 : 0;
    if (v[14:10] == 5'h1F) return v[15] ? 2 : 9;
    if (v[14:10] == 0 && v[9:0] == 0) return v[15] ? 5 : 6;
    if (v[14:10] == 0) return v[15] ? 4 : 7;
    return v[15] ? 3 : 8;
  endfunction

  function automatic logic [LANES-1:0] model();
    logic [LANES-1:0] r;
    for (int i = 0; i < LANES; i++) begin
      logic [9:0] s;
      s = lane_sel[i*10 +: 10];
      r[i] = exec_in[i] && s[cat_of(lane_val[i*16 +: 16])];
    end
    return r;
  endfunction

  task automatic chk(input string req, input logic [LANES-1:0] act, input logic [LANES-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic issue(input logic [7:0] op);
    @(negedge clk);
    req_vld = 1'b1;
    req_opc = op;
    @(negedge clk);
    req_vld = 1'b0;
  endtask

  task automatic t_reset();
    chk("R11 dst", dst_mask, '0);
    chk("R11 exec", exec_mask, '1);
    chk("R11 err", {63'b0, opc_err}, '0);
  endtask

  task automatic t_categories();
    exec_in = '1;
    for (int i = 0; i < LANES; i++) begin
      lane_val[i*16 +: 16] = rep(i % 10);
      lane_sel[i*10 +: 10] = 10'b1 << (i % 10);
    end
    issue(8'd20);
    chk("R1 R2 own category selected", dst_mask, '1);
    for (int i = 0; i < LANES; i++) lane_sel[i*10 +: 10] = ~(10'b1 << (i % 10));
    issue(8'd20);
    chk("R1 R2 own category deselected", dst_mask, '0);
  endtask

  task automatic t_nan();
    logic [15:0] pat [4] = '{16'h7E01, 16'h7D00, 16'hFE00, 16'hFC01};
    exec_in = '1;
    for (int i = 0; i < LANES; i++) begin
      lane_val[i*16 +: 16] = pat[i % 4];
      lane_sel[i*10 +: 10] = 10'b00_0000_0010; // quiet only
    end
    issue(8'd20);
    chk("R3 quiet select", dst_mask, {16{4'b0101}});
    chk("R3 quiet model", dst_mask, model());
    for (int i = 0; i < LANES; i++) lane_sel[i*10 +: 10] = 10'b00_0000_0001;
    issue(8'd20);
    chk("R3 signalling select", dst_mask, {16{4'b1010}});
  endtask

  task automatic t_denorm();
    logic [15:0] pat [4] = '{16'h0001, 16'h03FF, 16'h8001, 16'h0400};
    exec_in = '1;
    for (int i = 0; i < LANES; i++) begin
      lane_val[i*16 +: 16] = pat[i % 4];
      lane_sel[i*10 +: 10] = 10'b00_1001_0000; // both denormals
    end
    issue(8'd20);
    chk("R4 denormal select", dst_mask, {16{4'b0111}});
    for (int i = 0; i < LANES; i++) lane_sel[i*10 +: 10] = 10'b00_0110_0000; // both zeros
    issue(8'd20);
    chk("R4 not zero", dst_mask, '0);
  endtask

  task automatic t_multi_sel();
    exec_in = '1;
    for (int i = 0; i < LANES; i++) begin
      lane_val[i*16 +: 16] = (i % 3 == 0) ? 16'hC500 : (i % 3 == 1) ? 16'h7BFF : 16'h0000;
      lane_sel[i*10 +: 10] = 10'b01_0000_1000; // both normals
    end
    issue(8'd20);
    chk("R5 OR of categories", dst_mask, model());
  endtask

  task automatic t_disabled();
    exec_in = {32{2'b10}};
    for (int i = 0; i < LANES; i++) begin
      lane_val[i*16 +: 16] = rep(i % 10);
      lane_sel[i*10 +: 10] = '1;
    end
    issue(8'd20);
    chk("R6 disabled lanes zero", dst_mask, {32{2'b10}});
  endtask

  task automatic t_x_then_plain();
    exec_in = '1;
    for (int i = 0; i < LANES; i++) begin
      lane_val[i*16 +: 16] = rep(i % 10);
      lane_sel[i*10 +: 10] = 10'b1 << 8;
    end
    issue(8'd21);
    chk("R8 dst", dst_mask, model());
    chk("R8 exec", exec_mask, model());
    for (int i = 0; i < LANES; i++) lane_sel[i*10 +: 10] = 10'b1 << 3;
    issue(8'd20);
    chk("R7 dst", dst_mask, model());
    chk("R7 exec unchanged", exec_mask, {6{10'b01_0000_0000}} | 64'h0);
  endtask

  task automatic t_hold_and_bad();
    logic [LANES-1:0] d0, e0;
    d0 = dst_mask;
    e0 = exec_mask;
    for (int i = 0; i < LANES; i++) lane_sel[i*10 +: 10] = '1;
    exec_in = '1;
    req_opc = 8'd21;
    repeat (3) @(negedge clk);
    chk("R9 dst held", dst_mask, d0);
    chk("R9 exec held", exec_mask, e0);
    issue(8'd22);
    chk("R10 err raised", {63'b0, opc_err}, 64'd1);
    chk("R10 dst unchanged", dst_mask, d0);
    chk("R10 exec unchanged", exec_mask, e0);
    @(negedge clk);
    chk("R10 err one cycle", {63'b0, opc_err}, '0);
  endtask

  initial begin
    repeat (2) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_categories();
    t_nan();
    t_denorm();
    t_multi_sel();
    t_disabled();
    t_x_then_plain();
    t_hold_and_bad();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule